// File: doc/BRIEF.md
# Support Change Energy Detector

This block decides, frame by frame, whether the spectral support seen by a sub-Nyquist reconstruction path has changed. A vector of twelve pre-computed fixed-point weights (one row of a pseudo-inverse, produced elsewhere) is loaded through a small write port. Incoming samples arrive on a stream qualified by a valid bit. Each group of twelve valid samples forms one frame. Every sample in a frame is multiplied by the weight at its position, and the twelve products are added at full precision.

The square of that sum is the frame's energy. It is compared against an unsigned threshold held on an input port. When the energy is strictly greater than the threshold, a change flag rises for one clock cycle. Frames may follow each other without idle cycles. Cycles without a valid sample may fall anywhere inside a frame.

Top module: `scd_detector`

## Requirements
- R1: A frame is 12 valid samples. The k-th valid sample of a frame (k counted from 0) is multiplied by the weight held at address k. Counting starts from 0 after reset and after every completed frame.
- R2: Samples and weights are 18-bit two's complement with 12 fractional bits. The 12 products are summed exactly as a 40-bit signed value with 24 fractional bits. The energy is the exact square of that sum, an 80-bit unsigned value with 48 fractional bits.
- R3: The threshold is an 80-bit unsigned value in the energy format. The flag rises only when energy > threshold. Energy equal to the threshold gives no flag.
- R4: The flag is high for exactly one cycle per detecting frame. It is high in the 4th cycle after the rising clock edge that accepts the frame's 12th sample, and low in the cycles just before and after.
- R5: A cycle with sample_valid low neither advances the position in the frame nor contributes to the sum.
- R6: Frames may be back to back. Each frame's sum starts from zero, so an earlier frame never affects a later decision.
- R7: A weight is written when wt_we is high, wt_addr selects its position and wt_data gives its value. A weight is held until it is overwritten. Writes with an address of 12 or more change nothing.
- R8: A synchronous active-high reset clears the frame position, the partial sum, the pipeline and the flag. Stored weights are kept through a reset.
- R9: Full-scale inputs (all samples and weights at -2^17) give a sum of 12·2^34 without overflow and an exact energy of 144·2^68.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wt_we | input | 1 | Weight write enable |
| wt_addr | input | 4 | Weight position 0..11 |
| wt_data | input | 18 | Signed weight, 12 fractional bits |
| sample_valid | input | 1 | Sample qualifier |
| sample_data | input | 18 | Signed sample, 12 fractional bits |
| threshold | input | 80 | Unsigned energy threshold, 48 fractional bits |
| change_flag | output | 1 | One-cycle support-change indication |

## Verification
The two functions that can fall in the same cycle are the final accumulation of one frame, when its sum is handed to the squarer, and the start of the next frame, when the partial sum restarts. The decision pipeline also keeps working on frame n while frame n+1 streams in. The bench sends three frames back to back: a loud one, a quiet one whose energy is below the threshold, and another loud one. It counts exactly two flags. The quiet frame's energy plus any carried-over sum would have crossed the threshold, so a sum leaking from the loud frame would add a third flag. Separately, single frames are checked at the exact flag cycle and at its neighbours, with the threshold set one below, equal to and one above the computed energy.

// File: rtl/scd_pkg.sv
package scd_pkg;
  // Default sizing shared by the detector modules
  localparam int unsigned SCD_DATA_W    = 18;
  localparam int unsigned SCD_FRAC_W    = 12;
  localparam int unsigned SCD_FRAME_LEN = 12;
  localparam int unsigned SCD_GUARD_W   = 4;
endpackage

// File: rtl/scd_weight_bank.sv
module scd_weight_bank #(
  parameter int unsigned DATA_W    = 18,
  parameter int unsigned FRAME_LEN = 12,
  localparam int unsigned ADDR_W   = $clog2(FRAME_LEN)
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic signed [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic signed [DATA_W-1:0] rd_data
);
  // Plain array, write port plus registered read: maps onto block RAM
  logic signed [DATA_W-1:0] mem [FRAME_LEN];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr < ADDR_W'(FRAME_LEN)))
      mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/scd_mac.sv
module scd_mac #(
  parameter int unsigned DATA_W    = 18,
  parameter int unsigned FRAME_LEN = 12,
  parameter int unsigned GUARD_W   = 4,
  localparam int unsigned ADDR_W   = $clog2(FRAME_LEN),
  localparam int unsigned PROD_W   = 2 * DATA_W,
  localparam int unsigned ACC_W    = PROD_W + GUARD_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     s_valid,
  input  logic signed [DATA_W-1:0] s_data,
  output logic [ADDR_W-1:0]        wt_rd_addr,
  input  logic signed [DATA_W-1:0] wt_rd_data,
  output logic signed [ACC_W-1:0]  sum_q,
  output logic                     sum_v
);
  logic [ADDR_W-1:0]        pos;
  logic                     v1, last1, v2, last2;
  logic signed [DATA_W-1:0] smp_q;
  logic signed [PROD_W-1:0] prod_q;
  logic signed [ACC_W-1:0]  acc, acc_nxt;

  assign wt_rd_addr = pos;
  assign acc_nxt    = acc + ACC_W'(prod_q);

  // Stage 0: frame position, sample register aligned with weight read
  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= '0;
      v1    <= 1'b0;
      last1 <= 1'b0;
    end else begin
      v1    <= s_valid;
      last1 <= s_valid && (pos == ADDR_W'(FRAME_LEN - 1));
      if (s_valid)
        pos <= (pos == ADDR_W'(FRAME_LEN - 1)) ? '0 : pos + 1'b1;
    end
    smp_q <= s_data;
  end

  // Stage 1: full-width product
  always_ff @(posedge clk) begin
    if (rst) begin
      v2     <= 1'b0;
      last2  <= 1'b0;
      prod_q <= '0;
    end else begin
      v2     <= v1;
      last2  <= last1;
      prod_q <= PROD_W'(wt_rd_data) * PROD_W'(smp_q);
    end
  end

  // Stage 2: accumulate, hand off the frame total and restart
  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      sum_q <= '0;
      sum_v <= 1'b0;
    end else begin
      sum_v <= v2 && last2;
      if (v2) begin
        acc <= last2 ? '0 : acc_nxt;
        if (last2) sum_q <= acc_nxt;
      end
    end
  end

  // R1
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    pos < ADDR_W'(FRAME_LEN));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (pos == '0 && acc == '0 && !sum_v));

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    sum_v |-> (acc == '0 || $past(v1)));
endmodule

// File: rtl/scd_energy.sv
module scd_energy #(
  parameter int unsigned ACC_W    = 40,
  localparam int unsigned ENERGY_W = 2 * ACC_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ACC_W-1:0] sum_q,
  input  logic                    sum_v,
  input  logic [ENERGY_W-1:0]     threshold,
  output logic                    flag
);
  logic [ENERGY_W-1:0] energy_q;
  logic                e_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      energy_q <= '0;
      e_v      <= 1'b0;
      flag     <= 1'b0;
    end else begin
      e_v  <= sum_v;
      if (sum_v)
        energy_q <= $unsigned(ENERGY_W'(sum_q) * ENERGY_W'(sum_q));
      flag <= e_v && (energy_q > threshold);
    end
  end

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    flag |=> !flag);

  // R3
  strict_exceed_chk: assert property (@(posedge clk) disable iff (rst)
    flag |-> energy_q > $past(threshold));

  // R2
  energy_sign_chk: assert property (@(posedge clk) disable iff (rst)
    e_v |-> (energy_q[ENERGY_W-1] == 1'b0));
endmodule

// File: rtl/scd_detector.sv
module scd_detector
  import scd_pkg::*;
#(
  parameter int unsigned DATA_W    = SCD_DATA_W,
  parameter int unsigned FRAME_LEN = SCD_FRAME_LEN,
  parameter int unsigned GUARD_W   = SCD_GUARD_W,
  localparam int unsigned ADDR_W   = $clog2(FRAME_LEN),
  localparam int unsigned ACC_W    = 2 * DATA_W + GUARD_W,
  localparam int unsigned ENERGY_W = 2 * ACC_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wt_we,
  input  logic [ADDR_W-1:0]        wt_addr,
  input  logic signed [DATA_W-1:0] wt_data,
  input  logic                     sample_valid,
  input  logic signed [DATA_W-1:0] sample_data,
  input  logic [ENERGY_W-1:0]      threshold,
  output logic                     change_flag
);
  logic [ADDR_W-1:0]        rd_addr;
  logic signed [DATA_W-1:0] rd_data;
  logic signed [ACC_W-1:0]  sum_q;
  logic                     sum_v;

  scd_weight_bank #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) u_bank (
    .clk(clk), .wr_en(wt_we), .wr_addr(wt_addr), .wr_data(wt_data),
    .rd_addr(rd_addr), .rd_data(rd_data));

  scd_mac #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .GUARD_W(GUARD_W)) u_mac (
    .clk(clk), .rst(rst), .s_valid(sample_valid), .s_data(sample_data),
    .wt_rd_addr(rd_addr), .wt_rd_data(rd_data), .sum_q(sum_q), .sum_v(sum_v));

  scd_energy #(.ACC_W(ACC_W)) u_energy (
    .clk(clk), .rst(rst), .sum_q(sum_q), .sum_v(sum_v),
    .threshold(threshold), .flag(change_flag));
endmodule

// File: tb/scd_detector_test.sv
`timescale 1ns/1ps
module scd_detector_test;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               wt_we = 1'b0;
  logic [3:0]         wt_addr = '0;
  logic signed [17:0] wt_data = '0;
  logic               sample_valid = 1'b0;
  logic signed [17:0] sample_data = '0;
  logic [79:0]        threshold = '0;
  logic               change_flag;

  int compared = 0;
  int mismatched = 0;
  int flags_seen = 0;
  logic [31:0] lfsr = 32'h1ACE_5EED;
  logic signed [17:0] wts [12];
  logic signed [17:0] smp [12];

  always #2 clk = ~clk;

  scd_detector uut (
    .clk(clk), .rst(rst), .wt_we(wt_we), .wt_addr(wt_addr), .wt_data(wt_data),
    .sample_valid(sample_valid), .sample_data(sample_data),
    .threshold(threshold), .change_flag(change_flag));

  always @(negedge clk) if (!rst && change_flag) flags_seen++;

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [79:0] energy_of();
    logic signed [79:0] s = '0;
    for (int k = 0; k < 12; k++)
      s = s + 80'(wts[k]) * 80'(smp[k]);
    return $unsigned(s * s);
  endfunction

  task automatic load_weights();
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      wt_we = 1'b1; wt_addr = 4'(k); wt_data = wts[k];
    end
    @(negedge clk);
    wt_we = 1'b0;
  endtask

  task automatic stream(input bit gaps);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      sample_valid = 1'b1; sample_data = smp[k];
      if (gaps && (k % 3 == 1)) begin
        @(negedge clk);
        sample_valid = 1'b0; sample_data = 18'sh1FFFF;
      end
    end
  endtask

  // One isolated frame, flag checked at its exact cycle and neighbours
  task automatic run_frame(input bit gaps, input logic [79:0] thr, input string req);
    logic exp;
    threshold = thr;
    exp = energy_of() > thr;
    stream(gaps);
    @(negedge clk);
    sample_valid = 1'b0;
    repeat (3) @(negedge clk);
    check({req, " R4 before"}, 80'(change_flag), 80'(0));
    @(negedge clk);
    check(req, 80'(change_flag), 80'(exp));
    @(negedge clk);
    check({req, " R4 after"}, 80'(change_flag), 80'(0));
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [79:0] e;
    repeat (3) @(negedge clk);
    check("R8 reset flag", 80'(change_flag), 80'(0));
    rst = 1'b0;

    // Sweep: random weights and samples, threshold below / equal / above
    for (int f = 0; f < 30; f++) begin
      if (f % 3 == 0) begin
        for (int k = 0; k < 12; k++) begin lfsr = step(lfsr); wts[k] = lfsr[17:0]; end
        load_weights();
      end
      for (int k = 0; k < 12; k++) begin lfsr = step(lfsr); smp[k] = lfsr[20:3]; end
      e = energy_of();
      case (f % 3)
        0: run_frame(f[0], (e == 0) ? 80'(0) : e - 1, "R1 R2 R3 exceed");
        1: run_frame(f[0], e, "R3 equal no flag");
        default: run_frame(f[0], e + 1, "R3 above no flag");
      endcase
    end

    // R5: idle cycles with garbage data inside a frame
    for (int k = 0; k < 12; k++) begin wts[k] = 18'sd4096; smp[k] = 18'(k * 100); end
    load_weights();
    e = energy_of();
    run_frame(1'b1, e - 1, "R5 gaps flag");
    run_frame(1'b1, e, "R5 gaps equal");

    // R7: out-of-range write is dropped
    @(negedge clk);
    wt_we = 1'b1; wt_addr = 4'd13; wt_data = -18'sd5000;
    @(negedge clk);
    wt_we = 1'b1; wt_addr = 4'd12; wt_data = -18'sd7000;
    @(negedge clk);
    wt_we = 1'b0;
    run_frame(1'b0, e - 1, "R7 high address ignored");
    run_frame(1'b0, e, "R7 weights held");

    // R9: full scale
    for (int k = 0; k < 12; k++) begin wts[k] = -18'sd131072; smp[k] = -18'sd131072; end
    load_weights();
    e = energy_of();
    check("R9 energy value", e, 80'd144 << 68);
    run_frame(1'b0, e - 1, "R9 full scale flag");
    run_frame(1'b0, e, "R9 full scale equal");

    // R6: back to back loud / quiet / loud, threshold between them
    for (int k = 0; k < 12; k++) wts[k] = 18'sd4096;
    load_weights();
    threshold = 80'd1 << 60;
    flags_seen = 0;
    for (int k = 0; k < 12; k++) smp[k] = 18'sd60000;
    stream(1'b0);
    for (int k = 0; k < 12; k++) smp[k] = 18'sd1;
    stream(1'b0);
    for (int k = 0; k < 12; k++) smp[k] = -18'sd60000;
    stream(1'b0);
    @(negedge clk);
    sample_valid = 1'b0;
    repeat (8) @(negedge clk);
    check("R6 back to back flags", 80'(flags_seen), 80'(2));

    // R8: reset mid-frame, weights kept, next frame counts from 0
    for (int k = 0; k < 12; k++) smp[k] = 18'(k + 1) * 18'sd1000;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      sample_valid = 1'b1; sample_data = 18'sd99999;
    end
    @(negedge clk);
    sample_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R8 flag cleared", 80'(change_flag), 80'(0));
    e = energy_of();
    run_frame(1'b0, e - 1, "R8 after reset flag");
    run_frame(1'b0, e, "R8 after reset equal");

    finish_run();
  end
endmodule